// File: doc/BRIEF.md
# Line Rate Search Controller

This block finds a usable serial line rate for one transceiver channel. It has eight candidate rates, from 0.6144 Gbit/s at index 0 up to 6.144 Gbit/s at index 7. A mask chooses which of them take part. The block starts at the fastest enabled rate and stays on it for a programmable number of reference clock cycles. If the channel does not report synchronization in that time, it moves down to the next slower enabled rate. After the slowest enabled rate fails, it goes back to the fastest one and carries on without end.

While the search runs, the block drives the transmit rate, receive rate and PLL multiplier controls itself, and the values held in the management registers are set aside. Management writes still update those registers, but the outputs do not change. Management reads return the values being applied at that moment. Once synchronization is seen, the block stays on that rate. It resumes stepping downward only after synchronization has been absent for a whole dwell interval.

Top module: `rate_search_ctrl`

## Requirements
- R1: Once the search is enabled with a non-zero mask, the first rate applied is the highest enabled index. After that, each move goes to the next lower index whose mask bit is set, and indices whose mask bit is clear are skipped.
- R2: After the lowest enabled index has used up its dwell, the next rate applied is the highest enabled index again.
- R3: Each rate stays applied for exactly `dwell_cycles` clock cycles while sync is low, and a value of 0 behaves like 1. The dwell counter is 32 bits wide, which covers more than 4.5 s at 307.2 MHz.
- R4: The rate code for both TX and RX is 0 (full, scale 0.5) for indices 6–7, 1 (half, scale 1) for 4–5, 2 (quarter, scale 2) for 2–3 and 3 (eighth, scale 4) for 0–1.
- R5: The PLL multiplier depends on `ref_sel` and on the parity of the index. Even indices use the low value and odd indices use the high value. With ref_sel 0 (153.6 MHz) the values are 16 and 20. With 1 (122.88 MHz) they are 20 and 25. With 2 (307.2 MHz) they are 8 and 10. Code 3 behaves like 0.
- R6: If sync is high while searching, `locked` is set on the next cycle, and the rate does not change for as long as sync stays high.
- R7: While locked, a sync gap shorter than the dwell interval keeps the lock. A gap lasting a full dwell interval clears the lock, and the next lower enabled rate is applied from the next cycle.
- R8: While the search is active, management writes do not change `tx_rate`, `rx_rate` or `pll_mult`.
- R9: Management reads return the applied value of the addressed control. Address 0 returns the TX rate, 1 the RX rate, 2 the multiplier, and 3 reads as 0.
- R10: When `search_en` is low or `rate_mask` is zero, the outputs equal the register values and `locked` is 0.
- R11: When `search_en` falls, the register values are applied from the next cycle. Those values include any writes made during the search.
- R12: `lock_idx` gives the locked rate index while `locked` is 1, and 0 otherwise.
- R13: After reset, the registers hold TX rate 0, RX rate 0 and multiplier 16, and `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| search_en | input | 1 | Enables the rate search |
| rate_mask | input | 8 | One bit per candidate rate index |
| dwell_cycles | input | 32 | Cycles spent on each attempted rate |
| ref_sel | input | 2 | Reference clock selector for the multiplier |
| sync_ok | input | 1 | Channel synchronization indication |
| mgmt_wr_en | input | 1 | Management write strobe |
| mgmt_addr | input | 2 | Management register address |
| mgmt_wdata | input | 5 | Management write data |
| mgmt_rdata | output | 5 | Management read data (combinational) |
| tx_rate | output | 2 | Applied transmit rate code |
| rx_rate | output | 2 | Applied receive rate code |
| pll_mult | output | 5 | Applied PLL multiplier |
| locked | output | 1 | High while held on a synchronized rate |
| lock_idx | output | 3 | Index of the locked rate |

## Verification
Inputs change on the falling edge, and the outputs are sampled on a falling edge. The mode registers update on the rising edge in between, so a change of enable, sync or mask shows up at the first falling edge after it is driven. The sweep therefore samples each rate exactly `dwell_cycles` times (once when the dwell is 0) before it expects the next index. Lock is checked one cycle after sync rises. Loss of lock is checked after exactly the dwell count of low-sync cycles, with a gap one cycle shorter checked first. Read data is combinational, so it is compared within the same half cycle as the applied controls it mirrors.

// File: rtl/rsearch_pkg.sv
// Package rsearch_pkg
// Shared constants, state encoding and control bundle for the rate search.
// Assumes eight candidate rates in ascending order, index 0 slowest.
package rsearch_pkg;

    localparam int NUM_RATES = 8;
    localparam int IDX_W     = $clog2(NUM_RATES);
    localparam int RATE_W    = 2;
    localparam int MULT_W    = 5;
    localparam int REFSEL_W  = 2;
    localparam int ADDR_W    = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_HOLD = 2'd2
    } srch_state_e;

    typedef struct packed {
        logic [RATE_W-1:0] tx_rate;
        logic [RATE_W-1:0] rx_rate;
        logic [MULT_W-1:0] pll_mult;
    } lane_cfg_t;

    // PLL multiplier for a reference clock selection and rate family
    function automatic logic [MULT_W-1:0] mult_for(input logic [REFSEL_W-1:0] rs,
                                                   input logic upper_family);
        logic [MULT_W-1:0] m;
        case (rs)
            2'd1:    m = upper_family ? MULT_W'(25) : MULT_W'(20);
            2'd2:    m = upper_family ? MULT_W'(10) : MULT_W'(8);
            default: m = upper_family ? MULT_W'(20) : MULT_W'(16);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rsearch_table.sv
// Module rsearch_table
// Maps a rate index and reference clock selection to the control bundle.
// Assumes even indices belong to the lower multiplier family and odd to the
// upper one, and that rate codes pair up two indices per scale step.
module rsearch_table
    import rsearch_pkg::*;
#(
    parameter int N = NUM_RATES
) (
    input  logic [IDX_W-1:0]    idx,
    input  logic [REFSEL_W-1:0] ref_sel,
    output lane_cfg_t           cfg
);

    localparam int TOP_PAIR = (N - 1) / 2;

    logic [RATE_W-1:0] rate_lut [N];

    // one rate code per index: fastest pair gets code 0
    for (genvar g = 0; g < N; g++) begin : g_rate
        assign rate_lut[g] = RATE_W'(TOP_PAIR - g / 2);
    end

    // combine the rate code and the reference-dependent multiplier
    always_comb begin
        cfg.tx_rate  = rate_lut[idx];
        cfg.rx_rate  = rate_lut[idx];
        cfg.pll_mult = mult_for(ref_sel, idx[0]);
    end

endmodule

// File: rtl/rsearch_seq.sv
// Module rsearch_seq
// Search state machine: picks the highest enabled rate, dwells on it,
// steps down through enabled rates with wrap, locks on sync and resumes
// after a full dwell without sync. Assumes the mask is sampled each cycle.
module rsearch_seq
    import rsearch_pkg::*;
#(
    parameter int N       = NUM_RATES,
    parameter int DWELL_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               search_en,
    input  logic [N-1:0]       rate_mask,
    input  logic [DWELL_W-1:0] dwell_cycles,
    input  logic               sync_ok,
    output srch_state_e        state,
    output logic [IDX_W-1:0]   idx
);

    logic               active;
    logic [DWELL_W-1:0] cnt;
    logic [DWELL_W-1:0] limit;
    logic [IDX_W-1:0]   top_idx;
    logic [IDX_W-1:0]   next_idx;
    logic               dwell_done;

    // highest set bit of the mask
    function automatic logic [IDX_W-1:0] top_enabled(input logic [N-1:0] m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // nearest enabled index below cur, wrapping to the top
    function automatic logic [IDX_W-1:0] lower_enabled(input logic [IDX_W-1:0] cur,
                                                       input logic [N-1:0] m);
        logic [IDX_W-1:0] r;
        r = cur;
        for (int k = N - 1; k >= 1; k--) begin
            int c;
            c = (int'(cur) - k + N) % N;
            if (m[c]) r = IDX_W'(c);
        end
        return r;
    endfunction

    // decode search activity, dwell limit and candidate indices
    always_comb begin
        active     = search_en && (|rate_mask);
        limit      = (dwell_cycles == '0) ? '0 : dwell_cycles - DWELL_W'(1);
        dwell_done = (cnt >= limit);
        top_idx    = top_enabled(rate_mask);
        next_idx   = lower_enabled(idx, rate_mask);
    end

    // state, index and dwell counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            cnt   <= '0;
        end else if (!active) begin
            state <= ST_IDLE;
            idx   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state <= ST_HUNT;
                    idx   <= top_idx;
                    cnt   <= '0;
                end
                ST_HUNT: begin
                    if (sync_ok) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                    end else if (dwell_done) begin
                        idx <= next_idx;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + DWELL_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (sync_ok) begin
                        cnt <= '0;
                    end else if (dwell_done) begin
                        state <= ST_HUNT;
                        idx   <= next_idx;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + DWELL_W'(1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R6: sync while hunting locks on the same index next cycle
    p_lock_on_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && state == ST_HUNT && sync_ok) |=> (state == ST_HOLD && $stable(idx)));

    // R6: a held lock with sync present stays put
    p_hold_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && state == ST_HOLD && sync_ok) |=> (state == ST_HOLD && $stable(idx)));

    // R3: dwell counter never passes the limit while the limit is steady
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $stable(dwell_cycles)) |-> (cnt <= limit));

    // R1: a step during the hunt lands on an enabled index
    p_step_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && $past(state) == ST_HUNT && idx != $past(idx)
         && $stable(rate_mask)) |-> rate_mask[idx]);

    // R10: inactive search returns to idle
    p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state == ST_IDLE));

endmodule

// File: rtl/rsearch_regs.sv
// Module rsearch_regs
// Management registers for the rate and multiplier controls, override
// multiplexer and live read-back. Writes are always stored; the override
// selects the search values for both outputs and reads.
module rsearch_regs
    import rsearch_pkg::*;
#(
    parameter int RST_MULT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MULT_W-1:0] wdata,
    input  logic              override,
    input  lane_cfg_t         live_cfg,
    output lane_cfg_t         applied,
    output logic [MULT_W-1:0] rdata
);

    lane_cfg_t stored;

    // store management writes regardless of the search
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored.tx_rate  <= '0;
            stored.rx_rate  <= '0;
            stored.pll_mult <= MULT_W'(RST_MULT);
        end else if (wr_en) begin
            case (addr)
                2'd0:    stored.tx_rate  <= wdata[RATE_W-1:0];
                2'd1:    stored.rx_rate  <= wdata[RATE_W-1:0];
                2'd2:    stored.pll_mult <= wdata;
                default: ;
            endcase
        end
    end

    // choose the search values while the search owns the controls
    always_comb applied = override ? live_cfg : stored;

    // read back the applied value of the addressed control
    always_comb begin
        case (addr)
            2'd0:    rdata = MULT_W'(applied.tx_rate);
            2'd1:    rdata = MULT_W'(applied.rx_rate);
            2'd2:    rdata = applied.pll_mult;
            default: rdata = '0;
        endcase
    end

    // R11: a rate write is held in the register on the next cycle
    p_write_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> (stored.tx_rate == $past(wdata[RATE_W-1:0])));

    // R8: writes during an ongoing override leave the applied multiplier alone
    p_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (override && wr_en && $stable(live_cfg)) |=> (!override || applied.pll_mult == $past(applied.pll_mult)));

endmodule

// File: rtl/rate_search_ctrl.sv
// Module rate_search_ctrl
// Top of the line rate search: sequencer, rate table and register override.
// Assumes all inputs are synchronous to clk; read data is combinational.
module rate_search_ctrl
    import rsearch_pkg::*;
#(
    parameter int DWELL_W  = 32,
    parameter int RST_MULT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 search_en,
    input  logic [NUM_RATES-1:0] rate_mask,
    input  logic [DWELL_W-1:0]   dwell_cycles,
    input  logic [REFSEL_W-1:0]  ref_sel,
    input  logic                 sync_ok,
    input  logic                 mgmt_wr_en,
    input  logic [ADDR_W-1:0]    mgmt_addr,
    input  logic [MULT_W-1:0]    mgmt_wdata,
    output logic [MULT_W-1:0]    mgmt_rdata,
    output logic [RATE_W-1:0]    tx_rate,
    output logic [RATE_W-1:0]    rx_rate,
    output logic [MULT_W-1:0]    pll_mult,
    output logic                 locked,
    output logic [IDX_W-1:0]     lock_idx
);

    srch_state_e      state;
    logic [IDX_W-1:0] idx;
    lane_cfg_t        live_cfg;
    lane_cfg_t        applied;
    logic             override;

    rsearch_seq #(.N(NUM_RATES), .DWELL_W(DWELL_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .search_en    (search_en),
        .rate_mask    (rate_mask),
        .dwell_cycles (dwell_cycles),
        .sync_ok      (sync_ok),
        .state        (state),
        .idx          (idx)
    );

    rsearch_table #(.N(NUM_RATES)) u_table (
        .idx     (idx),
        .ref_sel (ref_sel),
        .cfg     (live_cfg)
    );

    rsearch_regs #(.RST_MULT(RST_MULT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mgmt_wr_en),
        .addr     (mgmt_addr),
        .wdata    (mgmt_wdata),
        .override (override),
        .live_cfg (live_cfg),
        .applied  (applied),
        .rdata    (mgmt_rdata)
    );

    // the search owns the controls whenever it is out of idle
    always_comb override = (state != ST_IDLE);

    // drive the controls and the lock status
    always_comb begin
        tx_rate  = applied.tx_rate;
        rx_rate  = applied.rx_rate;
        pll_mult = applied.pll_mult;
        locked   = (state == ST_HOLD);
        lock_idx = (state == ST_HOLD) ? idx : '0;
    end

    // R12: lock index reads zero whenever not locked
    p_idx_zero_unlocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (lock_idx == '0));

endmodule

// File: tb/test_rate_search_ctrl.sv
`timescale 1ns/1ps
module test_rate_search_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        search_en;
    logic [7:0]  rate_mask;
    logic [31:0] dwell_cycles;
    logic [1:0]  ref_sel;
    logic        sync_ok;
    logic        mgmt_wr_en;
    logic [1:0]  mgmt_addr;
    logic [4:0]  mgmt_wdata;
    logic [4:0]  mgmt_rdata;
    logic [1:0]  tx_rate;
    logic [1:0]  rx_rate;
    logic [4:0]  pll_mult;
    logic        locked;
    logic [2:0]  lock_idx;

    int checks = 0;
    int errors = 0;
    int reg_tx = 0;
    int reg_rx = 0;
    int reg_mult = 16;

    always #5 clk = ~clk;

    rate_search_ctrl i_rate_search_ctrl (
        .clk(clk), .rst_n(rst_n), .search_en(search_en), .rate_mask(rate_mask),
        .dwell_cycles(dwell_cycles), .ref_sel(ref_sel), .sync_ok(sync_ok),
        .mgmt_wr_en(mgmt_wr_en), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
        .mgmt_rdata(mgmt_rdata), .tx_rate(tx_rate), .rx_rate(rx_rate),
        .pll_mult(pll_mult), .locked(locked), .lock_idx(lock_idx)
    );

    function automatic int exp_rate(input int i);
        return 3 - i / 2;
    endfunction

    function automatic int exp_mult(input int rs, input int i);
        int lo, hi;
        if (rs == 1) begin lo = 20; hi = 25; end
        else if (rs == 2) begin lo = 8; hi = 10; end
        else begin lo = 16; hi = 20; end
        return (i % 2 == 1) ? hi : lo;
    endfunction

    function automatic int highest(input logic [7:0] m);
        int r = 0;
        for (int i = 0; i < 8; i++) if (m[i]) r = i;
        return r;
    endfunction

    function automatic int step_down(input int cur, input logic [7:0] m);
        for (int k = 1; k <= 8; k++) begin
            int c = (cur - k + 8) % 8;
            if (m[c]) return c;
        end
        return cur;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // compare applied controls and their read-back
    task automatic check_applied(input int et, input int er, input int em, input string req);
        chk(int'(tx_rate) == et, req, int'(tx_rate), et);
        chk(int'(rx_rate) == er, req, int'(rx_rate), er);
        chk(int'(pll_mult) == em, req, int'(pll_mult), em);
        mgmt_addr = 2'd0; #1;
        chk(int'(mgmt_rdata) == et, {req, " R9 rd0"}, int'(mgmt_rdata), et);
        mgmt_addr = 2'd1; #1;
        chk(int'(mgmt_rdata) == er, {req, " R9 rd1"}, int'(mgmt_rdata), er);
        mgmt_addr = 2'd2; #1;
        chk(int'(mgmt_rdata) == em, {req, " R9 rd2"}, int'(mgmt_rdata), em);
        mgmt_addr = 2'd3; #1;
        chk(mgmt_rdata == 5'd0, "R9 rd3", int'(mgmt_rdata), 0);
    endtask

    task automatic mgmt_write(input int a, input int v);
        @(negedge clk);
        mgmt_wr_en = 1'b1; mgmt_addr = 2'(a); mgmt_wdata = 5'(v);
        @(negedge clk);
        mgmt_wr_en = 1'b0;
        if (a == 0) reg_tx = v % 4;
        if (a == 1) reg_rx = v % 4;
        if (a == 2) reg_mult = v;
    endtask

    // R1 R2 R3 R4 R5: walk the full cycle of enabled rates plus one wrap
    task automatic run_sweep(input logic [7:0] m, input int rs, input int d);
        int cur, visits, per;
        @(negedge clk);
        rate_mask = m; ref_sel = 2'(rs); dwell_cycles = 32'(d); search_en = 1'b1;
        cur = highest(m);
        visits = $countones(m) + 1;
        per = (d == 0) ? 1 : d;
        for (int v = 0; v < visits; v++) begin
            for (int s = 0; s < per; s++) begin
                @(negedge clk);
                check_applied(exp_rate(cur), exp_rate(cur), exp_mult(rs, cur), "R1 R2 R3 R4 R5 R8");
                chk(locked == 1'b0, "R12 unlocked", int'(locked), 0);
            end
            cur = step_down(cur, m);
        end
        search_en = 1'b0;
        @(negedge clk);
        check_applied(reg_tx, reg_rx, reg_mult, "R10 R11 disabled");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] masks [6];
        int dws [3];
        masks[0] = 8'hFF; masks[1] = 8'h81; masks[2] = 8'h5A;
        masks[3] = 8'h01; masks[4] = 8'h80; masks[5] = 8'h24;
        dws[0] = 0; dws[1] = 2; dws[2] = 3;
        rst_n = 1'b0; search_en = 1'b0; rate_mask = 8'h00; dwell_cycles = 32'd3;
        ref_sel = 2'd0; sync_ok = 1'b0; mgmt_wr_en = 1'b0; mgmt_addr = 2'd0; mgmt_wdata = 5'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset values
        check_applied(0, 0, 16, "R13 reset");
        chk(locked == 1'b0, "R13 locked", int'(locked), 0);
        chk(lock_idx == 3'd0, "R12 R13 lock_idx", int'(lock_idx), 0);

        // R10: enabled with an empty mask keeps the registers
        mgmt_write(0, 2); mgmt_write(1, 1); mgmt_write(2, 12);
        search_en = 1'b1; rate_mask = 8'h00;
        repeat (3) begin
            @(negedge clk);
            check_applied(reg_tx, reg_rx, reg_mult, "R10 empty mask");
            chk(locked == 1'b0, "R10 locked", int'(locked), 0);
        end
        search_en = 1'b0;

        // R1 R2 R3 R4 R5 sweeps
        foreach (masks[mi])
            for (int rs = 0; rs < 4; rs++)
                foreach (dws[di])
                    run_sweep(masks[mi], rs, dws[di]);

        // R8 R11: writes during the search are stored but not applied
        @(negedge clk);
        rate_mask = 8'h10; ref_sel = 2'd2; dwell_cycles = 32'd5; search_en = 1'b1;
        @(negedge clk);
        check_applied(1, 1, 8, "R8 before write");
        mgmt_write(0, 3); mgmt_write(1, 2); mgmt_write(2, 25);
        check_applied(1, 1, 8, "R8 after write");
        search_en = 1'b0;
        @(negedge clk);
        check_applied(3, 2, 25, "R11 kept writes");

        // R6 R7 R12 lock behaviour
        @(negedge clk);
        rate_mask = 8'hFF; ref_sel = 2'd1; dwell_cycles = 32'd4; search_en = 1'b1; sync_ok = 1'b0;
        @(negedge clk);
        sync_ok = 1'b1;
        @(negedge clk);
        chk(locked == 1'b1, "R6 lock", int'(locked), 1);
        chk(lock_idx == 3'd7, "R12 lock_idx", int'(lock_idx), 7);
        check_applied(0, 0, 25, "R6 locked rate");
        repeat (8) @(negedge clk);
        chk(locked == 1'b1, "R6 hold", int'(locked), 1);
        check_applied(0, 0, 25, "R6 held rate");
        sync_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk(locked == 1'b1, "R7 short gap", int'(locked), 1);
        sync_ok = 1'b1;
        @(negedge clk);
        chk(locked == 1'b1, "R7 regain", int'(locked), 1);
        sync_ok = 1'b0;
        repeat (4) @(negedge clk);
        chk(locked == 1'b0, "R7 lost", int'(locked), 0);
        chk(lock_idx == 3'd0, "R12 cleared", int'(lock_idx), 0);
        check_applied(0, 0, 20, "R7 next lower");
        repeat (3) @(negedge clk);
        check_applied(0, 0, 20, "R3 R7 dwell at 6");
        @(negedge clk);
        check_applied(1, 1, 25, "R1 R7 step to 5");
        search_en = 1'b0;
        @(negedge clk);
        check_applied(reg_tx, reg_rx, reg_mult, "R11 after lock");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule